// File: doc/BRIEF.md
# Adaptive Read-Write Mode Arbiter

This block decides which class of column command a DRAM scheduler is allowed to send next. There are four classes: reads to rank 0, reads to rank 1, writes to rank 0 and writes to rank 1. The scheduler presents how many commands of each class it is holding. The arbiter answers with the class it is currently serving and a flag that says whether a command of that class may go out this cycle. When a command goes out, the scheduler reports it with a one-cycle strobe, its direction and its rank.

The arbiter spaces column commands by the pair of the previous and the next command. A write followed by a read on the same rank costs far more than any other pair, so when the arbiter leaves a write class it moves to a read on the other rank before a read on the same rank. Backlog thresholds are set per class and can be changed at run time. Once the current class has sent a minimum burst, a class whose backlog goes over its threshold takes the bus. The current class also gives way when it runs dry. A class that has waited too long with work pending takes the bus before any other choice is made. When no class has work, the arbiter holds its class and reports idle.

Top module: `rw_mode_arbiter`

## Requirements
- R1: After reset the class is read on rank 0 (encoding: bit 1 = write, bit 0 = rank, so 0 = read rank 0, 1 = read rank 1, 2 = write rank 0, 3 = write rank 1), no command is on record, and issue_ok is low while every pending count is zero.
- R2: issue_ok is high exactly when the current class has a nonzero pending count and, if any command has been reported since reset, at least the required gap has elapsed. If the last reported command went out at clock edge k, the earliest edge for the next command is k plus the gap.
- R3: On the same rank, the gap is 8 + gap_rd_rd for read then read, 16 + gap_rd_wr for read then write, 69 + gap_wr_rd for write then read, and 8 + gap_wr_wr for write then write. Each sum saturates at 255.
- R4: When the rank changes, write then read needs only 10 + gap_wr_rd. The other three pairs use the same values as in R3.
- R5: If the current class has no pending work and another class does, the class changes at the next edge. The first class with work is taken in this order. From a read: read on the other rank, then write on the same rank, then write on the other rank. From a write: write on the other rank, then read on the other rank, then read on the same rank.
- R6: If the current class still has work and its burst count (commands reported since it was entered, saturating) is at least min_burst, then the first class in the R5 order whose pending count is above its own threshold is taken at the next edge.
- R7: While the burst count is below min_burst, a class over its threshold does not cause a change, and the current class with work is kept.
- R8: A class ages by one for every cycle in which it has work and is not current. When starve_lim is nonzero and a class's age reaches starve_lim, it is taken at the next edge ahead of any R5 or R6 choice, in the R5 order. A starve_lim of zero turns this off.
- R9: When every pending count is zero, idle is high and the class does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_cnt | input | 4*CW | Pending count per class, class i in bits [i*CW +: CW] |
| issue_v | input | 1 | A column command was sent this cycle |
| issue_wr | input | 1 | Direction of the sent command, 1 = write |
| issue_rank | input | 1 | Rank of the sent command |
| gap_rd_rd | input | 8 | Extra spacing for read then read |
| gap_rd_wr | input | 8 | Extra spacing for read then write |
| gap_wr_rd | input | 8 | Extra spacing for write then read |
| gap_wr_wr | input | 8 | Extra spacing for write then write |
| backlog_thr | input | 4*CW | Backlog threshold per class, same layout as pend_cnt |
| min_burst | input | CW | Commands the current class must send before a backlog can take over |
| starve_lim | input | AW | Age limit for forcing a class change, 0 = off |
| mode | output | 2 | Current class (bit 1 = write, bit 0 = rank) |
| issue_ok | output | 1 | A command of the current class may be sent this cycle |
| idle | output | 1 | No class has pending work |

## Verification
The bench compares the gap flag every cycle against its own table of all sixteen previous/next pairs. If the design used the same-rank write-to-read cost across ranks, issue_ok would stay low 59 extra cycles. If it dropped the extra-gap inputs, issue_ok would rise early. The bench predicts the class choice every cycle under phases that change the burst minimum, the thresholds and the age limit, and that bias arrivals toward writes. A swapped priority order would show up on the wrong rank after a drain. A missing burst guard would switch too early. An age counter that never forces a switch would break the bench's own wait bound. A last phase with no work checks that the class holds and that idle stays high.

// File: rtl/rwarb_pkg.sv
`timescale 1ns/1ps
package rwarb_pkg;
  localparam int NMODE = 4;
  localparam int GAP_W = 8;

  typedef logic [GAP_W-1:0] gap_t;
  typedef logic [1:0]       mode_t;   // [1] = write, [0] = rank

  typedef struct packed {
    gap_t rr;
    gap_t rw;
    gap_t wr;
    gap_t ww;
  } gap_set_t;

  function automatic gap_t sat_add(gap_t a, gap_t b);
    logic [GAP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[GAP_W] ? {GAP_W{1'b1}} : s[GAP_W-1:0];
  endfunction

  // Spacing required between a previous command and the next one.
  function automatic gap_t gap_needed(logic pw, logic pr, logic nw, logic nr,
                                      gap_set_t base, gap_t base_xwr, gap_set_t xtra);
    gap_t r;
    unique case ({pw, nw})
      2'b00:   r = sat_add(base.rr, xtra.rr);
      2'b01:   r = sat_add(base.rw, xtra.rw);
      2'b10:   r = sat_add((pr == nr) ? base.wr : base_xwr, xtra.wr);
      default: r = sat_add(base.ww, xtra.ww);
    endcase
    return r;
  endfunction

  // k-th candidate when leaving cur; from a write the other-rank read comes before the same-rank read.
  function automatic mode_t cand_mode(mode_t cur, int unsigned k);
    mode_t r;
    case (k)
      0:       r = cur ^ 2'b01;
      1:       r = cur[1] ? (cur ^ 2'b11) : (cur ^ 2'b10);
      default: r = cur[1] ? (cur ^ 2'b10) : (cur ^ 2'b11);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rwarb_gap_timer.sv
`timescale 1ns/1ps
module rwarb_gap_timer import rwarb_pkg::*; #(
  parameter gap_t T_RR  = 8'd8,
  parameter gap_t T_RW  = 8'd16,
  parameter gap_t T_WR  = 8'd69,
  parameter gap_t T_WW  = 8'd8,
  parameter gap_t T_XWR = 8'd10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     issue_v,
  input  logic     issue_wr,
  input  logic     issue_rank,
  input  gap_set_t xtra,
  input  mode_t    cur_mode,
  output gap_t     need,
  output logic     gap_met
);
  localparam gap_set_t BASE = {T_RR, T_RW, T_WR, T_WW};

  logic have_prev, prev_wr, prev_rank;
  gap_t since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      prev_rank <= 1'b0;
      since     <= '0;
    end else if (issue_v) begin
      have_prev <= 1'b1;
      prev_wr   <= issue_wr;
      prev_rank <= issue_rank;
      since     <= gap_t'(1);
    end else if (since != {GAP_W{1'b1}}) begin
      since <= since + gap_t'(1);
    end
  end

  assign need    = gap_needed(prev_wr, prev_rank, cur_mode[1], cur_mode[0], BASE, T_XWR, xtra);
  assign gap_met = !have_prev || (since >= need);
endmodule

// File: rtl/rwarb_age.sv
`timescale 1ns/1ps
module rwarb_age import rwarb_pkg::*; #(
  parameter int CW = 6,
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMODE*CW-1:0] pend,
  input  mode_t             cur_mode,
  input  logic [AW-1:0]     limit,
  output logic [NMODE-1:0]  starved
);
  for (genvar i = 0; i < NMODE; i++) begin : g_mode
    logic [AW-1:0] age_q;
    logic busy, is_cur;
    assign busy   = pend[i*CW +: CW] != '0;
    assign is_cur = (cur_mode == mode_t'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)               age_q <= '0;
      else if (is_cur || !busy) age_q <= '0;
      else if (age_q != '1)     age_q <= age_q + AW'(1);
    end

    assign starved[i] = (limit != '0) && busy && !is_cur && (age_q >= limit);
  end
endmodule

// File: rtl/rwarb_select.sv
`timescale 1ns/1ps
module rwarb_select import rwarb_pkg::*; #(
  parameter int CW = 6
) (
  input  mode_t               cur_mode,
  input  logic [NMODE*CW-1:0] pend,
  input  logic [NMODE*CW-1:0] thr,
  input  logic [CW-1:0]       burst,
  input  logic [CW-1:0]       min_burst,
  input  logic [NMODE-1:0]    starved,
  output mode_t               nxt_mode
);
  logic [CW-1:0] cur_pend;
  mode_t         c;
  logic          found;

  assign cur_pend = pend[cur_mode*CW +: CW];

  always_comb begin
    nxt_mode = cur_mode;
    found    = 1'b0;
    c        = '0;
    for (int unsigned k = 0; k < 3; k++) begin
      c = cand_mode(cur_mode, k);
      if (!found && starved[c]) begin
        found = 1'b1; nxt_mode = c;
      end
    end
    if (!found && cur_pend == '0) begin
      for (int unsigned k = 0; k < 3; k++) begin
        c = cand_mode(cur_mode, k);
        if (!found && pend[c*CW +: CW] != '0) begin
          found = 1'b1; nxt_mode = c;
        end
      end
    end
    if (!found && cur_pend != '0 && burst >= min_burst) begin
      for (int unsigned k = 0; k < 3; k++) begin
        c = cand_mode(cur_mode, k);
        if (!found && pend[c*CW +: CW] > thr[c*CW +: CW]) begin
          found = 1'b1; nxt_mode = c;
        end
      end
    end
  end
endmodule

// File: rtl/rw_mode_arbiter.sv
`timescale 1ns/1ps
module rw_mode_arbiter import rwarb_pkg::*; #(
  parameter int   CW    = 6,
  parameter int   AW    = 10,
  parameter gap_t T_RR  = 8'd8,
  parameter gap_t T_RW  = 8'd16,
  parameter gap_t T_WR  = 8'd69,
  parameter gap_t T_WW  = 8'd8,
  parameter gap_t T_XWR = 8'd10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NMODE*CW-1:0] pend_cnt,
  input  logic                issue_v,
  input  logic                issue_wr,
  input  logic                issue_rank,
  input  logic [GAP_W-1:0]    gap_rd_rd,
  input  logic [GAP_W-1:0]    gap_rd_wr,
  input  logic [GAP_W-1:0]    gap_wr_rd,
  input  logic [GAP_W-1:0]    gap_wr_wr,
  input  logic [NMODE*CW-1:0] backlog_thr,
  input  logic [CW-1:0]       min_burst,
  input  logic [AW-1:0]       starve_lim,
  output logic [1:0]          mode,
  output logic                issue_ok,
  output logic                idle
);
  mode_t            mode_q, nxt_mode;
  logic [CW-1:0]    burst_q;
  logic [NMODE-1:0] starved;
  gap_set_t         xtra;
  gap_t             need;
  logic             gap_met, switch_ev;
  logic [CW-1:0]    cur_pend;

  assign xtra      = {gap_rd_rd, gap_rd_wr, gap_wr_rd, gap_wr_wr};
  assign cur_pend  = pend_cnt[mode_q*CW +: CW];
  assign switch_ev = (nxt_mode != mode_q);

  rwarb_gap_timer #(.T_RR(T_RR), .T_RW(T_RW), .T_WR(T_WR), .T_WW(T_WW), .T_XWR(T_XWR)) u_gap (
    .clk, .rst_n, .issue_v, .issue_wr, .issue_rank,
    .xtra(xtra), .cur_mode(mode_q), .need(need), .gap_met(gap_met)
  );

  rwarb_age #(.CW(CW), .AW(AW)) u_age (
    .clk, .rst_n, .pend(pend_cnt), .cur_mode(mode_q), .limit(starve_lim), .starved(starved)
  );

  rwarb_select #(.CW(CW)) u_sel (
    .cur_mode(mode_q), .pend(pend_cnt), .thr(backlog_thr), .burst(burst_q),
    .min_burst(min_burst), .starved(starved), .nxt_mode(nxt_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      burst_q <= '0;
    end else begin
      mode_q <= nxt_mode;
      if (switch_ev)                    burst_q <= '0;
      else if (issue_v && burst_q != '1) burst_q <= burst_q + CW'(1);
    end
  end

  assign mode     = mode_q;
  assign issue_ok = gap_met && (cur_pend != '0);
  assign idle     = (pend_cnt == '0);
endmodule

// File: rtl/rwarb_checker.sv
`timescale 1ns/1ps
module rwarb_checker import rwarb_pkg::*; #(
  parameter int CW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NMODE*CW-1:0] pend_cnt,
  input logic [1:0]          mode,
  input logic                issue_ok,
  input logic                idle,
  input logic                issue_v,
  input gap_t                need,
  input logic [NMODE-1:0]    starved
);
  gap_t             chk_since;
  logic             chk_have;
  logic [NMODE-1:0] starved_q;
  logic [CW-1:0]    mode_pend;

  assign mode_pend = pend_cnt[mode*CW +: CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_since <= '0;
      chk_have  <= 1'b0;
      starved_q <= '0;
    end else begin
      starved_q <= starved;
      if (issue_v) begin
        chk_have  <= 1'b1;
        chk_since <= gap_t'(1);
      end else if (chk_since != '1) begin
        chk_since <= chk_since + gap_t'(1);
      end
    end
  end

  a_r2_ok_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |-> (mode_pend != '0));

  // R3 and R4: permission never comes before the pair's spacing has elapsed
  a_r3_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && chk_have) |-> (chk_since >= need));

  a_r5_drain_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && mode_pend == '0) |=> (mode != $past(mode)));

  a_r8_starved_served: assert property (@(posedge clk) disable iff (!rst_n)
    (|starved) |=> starved_q[mode]);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (mode == $past(mode)));
endmodule

bind rw_mode_arbiter rwarb_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .mode(mode_q), .issue_ok(issue_ok),
  .idle(idle), .issue_v(issue_v), .need(need), .starved(starved)
);

// File: tb/tb_rw_mode_arbiter.sv
`timescale 1ns/1ps
module tb_rw_mode_arbiter;
  import rwarb_pkg::*;
  localparam int CW = 6;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4*CW-1:0] pend_cnt, backlog_thr;
  logic            issue_v, issue_wr, issue_rank;
  logic [7:0]      x_rr, x_rw, x_wr, x_ww;
  logic [CW-1:0]   min_burst;
  logic [AW-1:0]   starve_lim;
  logic [1:0]      mode;
  logic            issue_ok, idle;

  rw_mode_arbiter #(.CW(CW), .AW(AW)) dut (
    .clk, .rst_n, .pend_cnt, .issue_v, .issue_wr, .issue_rank,
    .gap_rd_rd(x_rr), .gap_rd_wr(x_rw), .gap_wr_rd(x_wr), .gap_wr_wr(x_ww),
    .backlog_thr, .min_burst, .starve_lim, .mode, .issue_ok, .idle
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int pend_b[4], thr_b[4], age_m[4], wc[4];
  int mode_m, burst_m, since_b, cause_m, lim_b;
  bit have_b, pw_b, pr_b;
  logic [15:0] lfsr = 16'hACE1;
  string tag_of[5] = '{"R7", "R5", "R6", "R8", "R9"};

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Spacing table restated from R3/R4
  function automatic int need_b(bit pw, bit pr, int nm);
    bit nw = (nm >= 2);
    bit nr = (nm % 2) == 1;
    int v;
    if (pw && !nw) v = ((pr == nr) ? 69 : 10) + int'(x_wr);
    else if (pw)   v = 8 + int'(x_ww);
    else if (nw)   v = 16 + int'(x_rw);
    else           v = 8 + int'(x_rr);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int cand(int m, int k);
    if (m >= 2) return (k == 0) ? (m ^ 1) : (k == 1) ? (m ^ 3) : (m ^ 2);
    return (k == 0) ? (m ^ 1) : (k == 1) ? (m ^ 2) : (m ^ 3);
  endfunction

  task automatic drive_inputs();
    for (int i = 0; i < 4; i++) begin
      pend_cnt[i*CW +: CW]    = CW'(pend_b[i]);
      backlog_thr[i*CW +: CW] = CW'(thr_b[i]);
    end
    starve_lim = AW'(lim_b);
  endtask

  task automatic model_edge();
    int nm, cause, c;
    bit fnd, anyp;
    anyp = 0;
    for (int i = 0; i < 4; i++) if (pend_b[i] != 0) anyp = 1;
    nm = mode_m; cause = anyp ? 0 : 4; fnd = 0;
    for (int k = 0; k < 3; k++) begin
      c = cand(mode_m, k);
      if (!fnd && lim_b != 0 && pend_b[c] != 0 && age_m[c] >= lim_b) begin
        fnd = 1; nm = c; cause = 3;
      end
    end
    if (!fnd && pend_b[mode_m] == 0)
      for (int k = 0; k < 3; k++) begin
        c = cand(mode_m, k);
        if (!fnd && pend_b[c] != 0) begin fnd = 1; nm = c; cause = 1; end
      end
    if (!fnd && pend_b[mode_m] != 0 && burst_m >= int'(min_burst))
      for (int k = 0; k < 3; k++) begin
        c = cand(mode_m, k);
        if (!fnd && pend_b[c] > thr_b[c]) begin fnd = 1; nm = c; cause = 2; end
      end
    for (int i = 0; i < 4; i++)
      age_m[i] = (i == mode_m || pend_b[i] == 0) ? 0 : ((age_m[i] < 1023) ? age_m[i] + 1 : 1023);
    if (nm != mode_m) burst_m = 0;
    else if (issue_v && burst_m < 63) burst_m++;
    if (issue_v) begin
      have_b = 1; pw_b = issue_wr; pr_b = issue_rank; since_b = 1;
    end else if (since_b < 255) since_b++;
    mode_m = nm; cause_m = cause;
  endtask

  task automatic one_cycle(int arr_rate, bit wbias);
    int m, need_now;
    bit ok_exp, idle_exp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (issue_v) begin
      m = (issue_wr ? 2 : 0) + (issue_rank ? 1 : 0);
      if (pend_b[m] > 0) pend_b[m]--;
    end
    issue_v = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (int'(lfsr[7:0]) < arr_rate) begin
      m = int'(lfsr[9:8]);
      if (wbias && lfsr[10]) m = m | 2;
      if (pend_b[m] < 63) pend_b[m]++;
    end
    drive_inputs();
    #1;
    need_now = need_b(pw_b, pr_b, mode_m);
    ok_exp   = (pend_b[mode_m] != 0) && (!have_b || since_b >= need_now);
    idle_exp = (pend_b[0] == 0) && (pend_b[1] == 0) && (pend_b[2] == 0) && (pend_b[3] == 0);
    check(int'(mode) == mode_m, tag_of[cause_m], "mode", int'(mode), mode_m);
    check(issue_ok == ok_exp, !have_b ? "R2" : ((pr_b == (mode_m % 2 == 1)) ? "R3" : "R4"),
          "issue_ok", int'(issue_ok), int'(ok_exp));
    check(idle == idle_exp, "R9", "idle", int'(idle), int'(idle_exp));
    for (int i = 0; i < 4; i++) begin
      if (pend_b[i] != 0 && int'(mode) != i) wc[i]++;
      else wc[i] = 0;
      if (lim_b != 0) check(wc[i] <= lim_b + 5, "R8", "wait bound", wc[i], lim_b + 5);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ok_exp && lfsr[1:0] != 2'b00) begin
      issue_v = 1; issue_wr = (mode_m >= 2); issue_rank = (mode_m % 2 == 1);
    end
  endtask

  initial begin
    int rates[6] = '{20, 28, 12, 40, 24, 16};
    int lims[6]  = '{0, 40, 90, 25, 150, 60};
    issue_v = 0; issue_wr = 0; issue_rank = 0;
    x_rr = 0; x_rw = 0; x_wr = 0; x_ww = 0;
    min_burst = 1;
    for (int i = 0; i < 4; i++) begin pend_b[i] = 0; thr_b[i] = 63; age_m[i] = 0; wc[i] = 0; end
    lim_b = 0;
    mode_m = 0; burst_m = 0; since_b = 0; cause_m = 0; have_b = 0; pw_b = 0; pr_b = 0;
    drive_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(mode == 2'd0, "R1", "reset mode", int'(mode), 0);
    check(idle == 1'b1, "R1", "reset idle", int'(idle), 1);
    check(issue_ok == 1'b0, "R1", "reset issue_ok", int'(issue_ok), 0);
    for (int p = 0; p < 6; p++) begin
      x_rr = 8'(p % 4); x_rw = 8'((p * 3) % 5); x_wr = 8'(p % 3); x_ww = 8'((p + 1) % 4);
      min_burst = CW'(1 + p % 4);
      lim_b = lims[p];
      for (int i = 0; i < 4; i++) begin thr_b[i] = 4 + ((p + i) * 5) % 20; wc[i] = 0; end
      drive_inputs();
      for (int n = 0; n < 3000; n++) one_cycle(rates[p], p[0]);
    end
    // R9: no work at all, class must hold and idle stay high
    lim_b = 40;
    for (int i = 0; i < 4; i++) pend_b[i] = 0;
    drive_inputs();
    for (int n = 0; n < 40; n++) one_cycle(0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule